// File: doc/BRIEF.md
# Programmable Interval Timer Bank

This block holds a small bank of independent 32-bit interval timers behind a simple register port. Each timer has three registers: a live counter, a two-bit control word and a terminal value. While counting is allowed, the counter advances by one on every clock. When it equals the terminal value, the next advancing clock returns it to zero and latches an event flag. The timer drives its interrupt line while that flag is set and the control word enables interrupts.

One timer design covers two uses. As an event tick, software loads the terminal value, clears the counter and then writes the control word, which also acknowledges any earlier event. The timer then repeats with a period of terminal value plus one clocks. As a free-running timebase, the terminal value is set to all ones, so the counter climbs monotonically and wraps from its maximum to zero. A control bit can hold the counter while the processor reports that it is halted.

Top module: `ivt_bank`

## Requirements
- R1: After a synchronous reset, every counter, control word and terminal value reads 0 and every interrupt output is low.
- R2: Timer 0 decodes its counter at address 0x21, its control word at 0x22 and its terminal value at 0x23. Timer 1 uses 0x100, 0x101 and 0x102 in the same order. A control read returns the stored bits [1:0] with zeros above them. A read of any other address returns 0, and a write to any other address changes nothing.
- R3: With counting allowed, the counter advances by exactly one per clock, and a read returns its live value.
- R4: On an advancing clock where the counter equals the terminal value, the counter becomes 0 and the event flag is set. Counting continues, so the event repeats every terminal+1 clocks.
- R5: With the terminal value at 0xFFFFFFFF, the counter passes from 0xFFFFFFFF to 0 and keeps rising.
- R6: A timer's interrupt output is high exactly when its event flag is set and control bit 0 (interrupt enable) is 1.
- R7: With control bit 1 (hold while halted) set, the counter keeps its value on every clock where the halted input is high. With bit 1 clear, the halted input has no effect.
- R8: Any write to the control register clears the event flag, whatever value is written.
- R9: If a control write and a terminal match fall on the same clock, the event flag ends up set.
- R10: A counter write takes priority over advancing on the same clock, even while counting is held. That clock cannot produce a terminal match.
- R11: Writes to one timer leave the registers and the interrupt of the other timer unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 12 | Register address |
| wr_en | input | 1 | Write strobe for the addressed register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed register (combinational) |
| halted | input | 1 | High while the processor is halted |
| irq | output | 2 | One interrupt line per timer |

## Verification
The acknowledge from a control write and the setting of the event flag on a terminal match can fall on the same clock. The bench provokes this by counting clocks after the counter is cleared and timing a control write for the clock where the counter equals the terminal value. The interrupt must then still be high while the counter reads 0. A second collision, a counter write on the clock of a match, is provoked the same way. That case is judged by the counter showing the written value and the interrupt staying low.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    localparam int DATA_W = 32;

    typedef logic [DATA_W-1:0] word_t;

    // Control word layout: bit 1 holds counting while halted, bit 0 enables the interrupt
    typedef struct packed {
        logic hold_on_halt;
        logic irq_en;
    } tctl_t;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_LIMIT = 2'd3
    } rsel_e;

    // Offsets of the three registers relative to a timer's base
    localparam int unsigned CNT_OFS = 0;
    localparam int unsigned CTL_OFS = 1;
    localparam int unsigned LIM_OFS = 2;

    // Timer 0 sits at 0x21, timer 1 at 0x100, further ones every 0x10 after that
    function automatic int unsigned chan_base(input int unsigned idx);
        if (idx == 0) return 32'h21;
        return 32'h100 + (idx - 1) * 32'h10;
    endfunction

    function automatic word_t ctl_to_word(input tctl_t c);
        return word_t'(c);
    endfunction

endpackage

// File: rtl/ivt_decode.sv
module ivt_decode
    import ivt_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NTIMER = 2
) (
    input  logic [ADDR_W-1:0] addr_i,
    output rsel_e             sel_o [NTIMER]
);

    for (genvar g = 0; g < NTIMER; g++) begin : g_dec
        localparam int unsigned BASE = chan_base(g);
        localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(BASE + CNT_OFS);
        localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(BASE + CTL_OFS);
        localparam logic [ADDR_W-1:0] A_LIM = ADDR_W'(BASE + LIM_OFS);

        always_comb begin
            if (addr_i == A_CNT)      sel_o[g] = SEL_COUNT;
            else if (addr_i == A_CTL) sel_o[g] = SEL_CTRL;
            else if (addr_i == A_LIM) sel_o[g] = SEL_LIMIT;
            else                      sel_o[g] = SEL_NONE;
        end
    end

endmodule

// File: rtl/ivt_counter.sv
module ivt_counter
    import ivt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick_i,
    input  logic  ld_i,
    input  word_t ld_val_i,
    input  word_t limit_i,
    input  logic  ack_i,
    output word_t count_o,
    output logic  pending_o
);

    word_t count_q;
    logic  pend_q;
    logic  hit;
    logic  wrap_evt;

    assign hit      = (count_q == limit_i);
    assign wrap_evt = tick_i && hit && !ld_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            pend_q  <= 1'b0;
        end else begin
            // software load wins over advancing
            if (ld_i)          count_q <= ld_val_i;
            else if (tick_i)   count_q <= hit ? '0 : count_q + 1'b1;
            // a terminal match outranks the acknowledge
            if (wrap_evt)      pend_q <= 1'b1;
            else if (ack_i)    pend_q <= 1'b0;
        end
    end

    assign count_o   = count_q;
    assign pending_o = pend_q;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (count_q == '0) && !pend_q);

    assert_step_R3: assert property (@(posedge clk) disable iff (rst)
        (!ld_i && tick_i && !hit) |=> count_q == $past(count_q) + 1'b1);

    assert_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (!ld_i && tick_i && hit) |=> (count_q == '0) && pend_q);

    assert_ack_R8: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !(tick_i && hit && !ld_i)) |=> !pend_q);

    assert_ack_vs_match_R9: assert property (@(posedge clk) disable iff (rst)
        (ack_i && tick_i && hit && !ld_i) |=> pend_q);

    assert_load_R10: assert property (@(posedge clk) disable iff (rst)
        ld_i |=> count_q == $past(ld_val_i));

endmodule

// File: rtl/ivt_channel.sv
module ivt_channel
    import ivt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  rsel_e sel_i,
    input  logic  wr_en_i,
    input  word_t wdata_i,
    input  logic  halted_i,
    output word_t rdata_o,
    output logic  irq_o
);

    tctl_t ctl_q;
    word_t lim_q;
    word_t cnt;
    logic  pend;
    logic  wr_cnt, wr_ctl, wr_lim;
    logic  tick;

    assign wr_cnt = wr_en_i && (sel_i == SEL_COUNT);
    assign wr_ctl = wr_en_i && (sel_i == SEL_CTRL);
    assign wr_lim = wr_en_i && (sel_i == SEL_LIMIT);

    assign tick = !(ctl_q.hold_on_halt && halted_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            lim_q <= '0;
        end else begin
            if (wr_ctl) ctl_q <= tctl_t'(wdata_i[1:0]);
            if (wr_lim) lim_q <= wdata_i;
        end
    end

    ivt_counter u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick),
        .ld_i      (wr_cnt),
        .ld_val_i  (wdata_i),
        .limit_i   (lim_q),
        .ack_i     (wr_ctl),
        .count_o   (cnt),
        .pending_o (pend)
    );

    always_comb begin
        unique case (sel_i)
            SEL_COUNT: rdata_o = cnt;
            SEL_CTRL:  rdata_o = ctl_to_word(ctl_q);
            SEL_LIMIT: rdata_o = lim_q;
            default:   rdata_o = '0;
        endcase
    end

    assign irq_o = pend && ctl_q.irq_en;

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!wr_cnt && ctl_q.hold_on_halt && halted_i) |=> $stable(cnt));

    assert_irq_gate_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_ctl && !wdata_i[0]) |=> !irq_o);

endmodule

// File: rtl/ivt_bank.sv
module ivt_bank
    import ivt_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NTIMER = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              halted,
    output logic [NTIMER-1:0] irq
);

    rsel_e             sel [NTIMER];
    word_t             ch_rd [NTIMER];
    logic [NTIMER-1:0] chan_hit;

    ivt_decode #(
        .ADDR_W (ADDR_W),
        .NTIMER (NTIMER)
    ) u_dec (
        .addr_i (addr),
        .sel_o  (sel)
    );

    for (genvar g = 0; g < NTIMER; g++) begin : g_chan
        assign chan_hit[g] = (sel[g] != SEL_NONE);

        ivt_channel u_ch (
            .clk      (clk),
            .rst      (rst),
            .sel_i    (sel[g]),
            .wr_en_i  (wr_en),
            .wdata_i  (wdata),
            .halted_i (halted),
            .rdata_o  (ch_rd[g]),
            .irq_o    (irq[g])
        );
    end

    // unselected channels drive zero, so an OR merges the readback
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NTIMER; i++) rdata = rdata | ch_rd[i];
    end

    assert_one_chan_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(chan_hit));

    assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (chan_hit == '0) |-> (rdata == '0));

endmodule

// File: tb/ivt_bank_test.sv
module ivt_bank_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        halted = 1'b0;
    logic [1:0]  irq;

    int n_chk  = 0;
    int n_fail = 0;

    localparam logic [11:0] T0_CNT = 12'h021, T0_CTL = 12'h022, T0_LIM = 12'h023;
    localparam logic [11:0] T1_CNT = 12'h100, T1_CTL = 12'h101, T1_LIM = 12'h102;

    always #5 clk = ~clk;

    ivt_bank uut (
        .clk    (clk),
        .rst    (rst),
        .addr   (addr),
        .wr_en  (wr_en),
        .wdata  (wdata),
        .rdata  (rdata),
        .halted (halted),
        .irq    (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a falling edge; performs the write on the next rising edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(T0_CNT, v); chk("R1 t0 count", v, 0);
        rd(T0_CTL, v); chk("R1 t0 ctrl", v, 0);
        rd(T0_LIM, v); chk("R1 t0 limit", v, 0);
        rd(T1_CNT, v); chk("R1 t1 count", v, 0);
        rd(T1_CTL, v); chk("R1 t1 ctrl", v, 0);
        rd(T1_LIM, v); chk("R1 t1 limit", v, 0);
        chk("R1 irq", {30'b0, irq}, 0);
    endtask

    task automatic t_periodic();
        logic [31:0] v;
        wr(T0_LIM, 5);
        wr(T0_CNT, 0);
        wr(T0_CTL, 1);
        idle(4);
        rd(T0_CNT, v); chk("R3 count advances", v, 5);
        chk("R6 no irq before match", {31'b0, irq[0]}, 0);
        idle(1);
        chk("R4 R6 irq after match", {31'b0, irq[0]}, 1);
        rd(T0_CNT, v); chk("R4 count back to 0", v, 0);
        wr(T0_CTL, 32'hFFFF_FFF1);
        chk("R8 ack any value", {31'b0, irq[0]}, 0);
        idle(4);
        chk("R4 quiet before second period", {31'b0, irq[0]}, 0);
        idle(1);
        chk("R4 periodic repeat", {31'b0, irq[0]}, 1);
    endtask

    task automatic t_ie_off();
        logic [31:0] v;
        wr(T0_CNT, 0);
        wr(T0_CTL, 0);
        idle(6);
        chk("R6 masked when enable clear", {31'b0, irq[0]}, 0);
        rd(T0_CNT, v); chk("R4 count after masked wrap", v, 1);
        wr(T0_CTL, 1);
        chk("R8 stale event cleared by ctrl write", {31'b0, irq[0]}, 0);
    endtask

    task automatic t_same_cycle();
        logic [31:0] v;
        wr(T0_CNT, 0);
        wr(T0_CTL, 1);
        idle(4);
        wr(T0_CTL, 1);   // lands on the clock where count equals the limit
        chk("R9 match beats ack", {31'b0, irq[0]}, 1);
        rd(T0_CNT, v); chk("R9 count wrapped", v, 0);
    endtask

    task automatic t_halt();
        logic [31:0] v;
        wr(T0_LIM, 32'hFFFF_FFFF);
        wr(T0_CNT, 100);
        wr(T0_CTL, 2);
        halted = 1'b1;
        idle(3);
        rd(T0_CNT, v); chk("R7 held while halted", v, 101);
        wr(T0_CNT, 7);
        rd(T0_CNT, v); chk("R10 load while held", v, 7);
        halted = 1'b0;
        idle(2);
        rd(T0_CNT, v); chk("R7 resumes", v, 9);
        wr(T0_CTL, 0);
        halted = 1'b1;
        idle(3);
        rd(T0_CNT, v); chk("R7 halted ignored when bit1 clear", v, 13);
        halted = 1'b0;
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        wr(T0_CNT, 32'hFFFF_FFFE);
        wr(T0_CTL, 1);
        rd(T0_CNT, v); chk("R5 at maximum", v, 32'hFFFF_FFFF);
        chk("R5 no irq before wrap", {31'b0, irq[0]}, 0);
        idle(1);
        rd(T0_CNT, v); chk("R5 wrapped to 0", v, 0);
        chk("R5 irq on wrap", {31'b0, irq[0]}, 1);
        idle(2);
        rd(T0_CNT, v); chk("R5 keeps rising", v, 2);
    endtask

    task automatic t_load_prio();
        logic [31:0] v;
        wr(T0_LIM, 3);
        wr(T0_CNT, 0);
        wr(T0_CTL, 1);
        idle(2);
        wr(T0_CNT, 10);  // lands on the clock where count equals the limit
        rd(T0_CNT, v); chk("R10 load wins", v, 10);
        chk("R10 no event on load clock", {31'b0, irq[0]}, 0);
        idle(1);
        rd(T0_CNT, v); chk("R10 continues from load", v, 11);
        chk("R10 still no event", {31'b0, irq[0]}, 0);
    endtask

    task automatic t_map();
        logic [31:0] v;
        wr(T0_CTL, 32'hFFFF_FFFD);
        rd(T0_CTL, v); chk("R2 ctrl readback bits", v, 1);
        rd(12'h050, v); chk("R2 unmapped read", v, 0);
        wr(T0_LIM, 32'h1234);
        wr(T1_LIM, 2);
        wr(T1_CNT, 0);
        wr(T1_CTL, 1);
        chk("R11 t1 quiet", {31'b0, irq[1]}, 0);
        idle(1);
        rd(T1_CNT, v); chk("R11 t1 count", v, 2);
        idle(1);
        chk("R11 t1 irq", {31'b0, irq[1]}, 1);
        rd(T0_LIM, v); chk("R11 t0 limit untouched", v, 32'h1234);
        wr(12'h050, 32'hFFFF_FFFF);
        rd(T0_LIM, v); chk("R2 unmapped write t0", v, 32'h1234);
        rd(T1_LIM, v); chk("R2 unmapped write t1", v, 2);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_periodic();
        t_ie_off();
        t_same_cycle();
        t_halt();
        t_wrap();
        t_load_prio();
        t_map();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule